// File: doc/BRIEF.md
# Low-Side Driver Channel Fault Controller

This block sequences protection and diagnosis for one channel of a dual low-side load driver. It takes the shared enable, the channel command input, a 1 µs timebase tick and a set of comparator flags from the analog front end. From these it drives the power-stage gate enable and one active-low diagnostic bit. The flags cover overcurrent, low output current while on, low output voltage while off, output below the neighbouring channel (a bypass to ground), flyback clamp reached, and over-temperature. Current limiting, slope control and clamping stay in the analog domain and appear here only as flags.

Every input passes through a two-stage synchroniser before any decision is made. An overcurrent that lasts for a programmable number of ticks sets an overload latch. The latch holds the gate off until the channel input falls. Over-temperature turns the gate off at once. The bypass comparison is blanked by the flyback clamp and is re-armed only by a falling edge of the input or of the enable. The diagnostic bit is high in healthy operation. It is pulled low by whichever fault applies to the present gate state.

Top module: `lsd_fault_ctrl`

## Requirements
- R1: The gate output goes high 3 clock cycles after both enable and input are high at the pins, provided no fault blocks it. The gate is low whenever either one was low 3 cycles earlier.
- R2: The gate is turned off only after overcurrent has been present, with the command on, for OVL_TICKS consecutive ticks. An overcurrent pulse shorter than that restarts the count and leaves the gate on.
- R3: Once the overload latch is set, the gate stays off and the diagnostic stays low. This holds even after the overcurrent clears and even through an enable low pulse. Only a falling edge of the channel input clears the latch.
- R4: Over-temperature turns the gate off and drives the diagnostic low 3 cycles after it appears at the pin. When the flag clears, the gate returns to its commanded state and the diagnostic returns high.
- R5: When over-temperature and overcurrent are both present while the command is on, the overload latch sets after the overload delay. The gate therefore stays off after the temperature flag clears.
- R6: While the gate is off, a low-output-voltage flag drives the diagnostic low.
- R7: While the gate is off, the bypass flag drives the diagnostic low. A clamp flag blocks this report. The report stays blocked until a falling edge of the input or the enable is seen after the clamp has ended.
- R8: While the gate is on, low output current drives the diagnostic low only after it has lasted OPEN_TICKS consecutive ticks. A shorter gap restarts the count.
- R9: With no fault condition, the diagnostic is high with the gate either on or off.
- R10: An active-low reset forces the gate low and the diagnostic high, and clears both latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| en_i | input | 1 | Shared channel enable |
| in_i | input | 1 | Channel command input |
| oc_i | input | 1 | Output current above overload threshold |
| ucur_i | input | 1 | Output current below open-load threshold |
| uvolt_i | input | 1 | Output voltage below open-load threshold |
| byp_i | input | 1 | Output below other channel minus offset |
| clamp_i | input | 1 | Flyback clamp voltage reached |
| otemp_i | input | 1 | Over-temperature, hysteretic |
| gate_o | output | 1 | Power stage gate enable |
| diag_n_o | output | 1 | Diagnostic, low on fault |

## Verification
The hardest state to reach from the pins is the blocked bypass latch. The clamp must arrive while the bypass flag stays high, and then the re-arm must come from an input falling edge in one case and an enable falling edge in another. The bench forces this with pulse trains on clamp, input and enable while holding the bypass flag. It uses the same kind of trains to keep overcurrent and low current just short of their tick limits, so the counter restart is observable. All flag combinations in static conditions are swept, and the expected gate and diagnostic are computed from the requirement equations.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef struct packed {
    logic en;
    logic in;
    logic oc;
    logic ucur;
    logic uvolt;
    logic byp;
    logic clamp;
    logic ot;
  } lsd_flags_t;

  localparam int LSD_NFLAGS = $bits(lsd_flags_t);
endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/lsd_delay.sv
module lsd_delay #(
  parameter int TERM = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic qual_i,
  output logic done_o
);
  localparam int CW = $clog2(TERM + 1);
  localparam logic [CW-1:0] TERM_C = CW'(TERM);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!qual_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick_i && (cnt_q != TERM_C)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done_o = qual_i && (cnt_q == TERM_C);
endmodule

// File: rtl/lsd_bypass.sv
module lsd_bypass (
  input  logic clk,
  input  logic rst_n,
  input  logic clamp_i,
  input  logic rearm_i,
  input  logic off_i,
  input  logic byp_i,
  output logic blk_o,
  output logic fault_o
);
  logic blk_q;
  logic blk_d;

  always_comb begin
    blk_d = blk_q;
    if (clamp_i) begin
      blk_d = 1'b1;
    end else if (rearm_i) begin
      blk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
    end else begin
      blk_q <= blk_d;
    end
  end

  assign blk_o   = blk_q;
  assign fault_o = off_i && byp_i && !blk_q && !clamp_i;
endmodule

// File: rtl/lsd_fault_ctrl.sv
module lsd_fault_ctrl #(
  parameter int OVL_TICKS  = 160,
  parameter int OPEN_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic en_i,
  input  logic in_i,
  input  logic oc_i,
  input  logic ucur_i,
  input  logic uvolt_i,
  input  logic byp_i,
  input  logic clamp_i,
  input  logic otemp_i,
  output logic gate_o,
  output logic diag_n_o
);
  import lsd_pkg::*;

  lsd_flags_t raw_flags;
  lsd_flags_t s;

  assign raw_flags = '{en: en_i, in: in_i, oc: oc_i, ucur: ucur_i,
                       uvolt: uvolt_i, byp: byp_i, clamp: clamp_i, ot: otemp_i};

  lsd_sync #(.W(LSD_NFLAGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_flags),
    .q_o   (s)
  );

  logic in_prev_q;
  logic en_prev_q;
  logic in_fall;
  logic en_fall;
  logic cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_prev_q <= 1'b0;
      en_prev_q <= 1'b0;
    end else begin
      in_prev_q <= s.in;
      en_prev_q <= s.en;
    end
  end

  assign in_fall = in_prev_q && !s.in;
  assign en_fall = en_prev_q && !s.en;
  assign cmd     = s.en && s.in;

  logic gate_q;
  logic gate_d;
  logic diag_q;
  logic diag_d;
  logic ovl_q;
  logic ovl_d;
  logic ovl_done;
  logic ol_done;
  logic byp_fault;
  logic byp_blk;
  logic fault_c;

  lsd_delay #(.TERM(OVL_TICKS)) u_ovl_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_us),
    .qual_i (cmd && s.oc),
    .done_o (ovl_done)
  );

  lsd_delay #(.TERM(OPEN_TICKS)) u_open_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_us),
    .qual_i (gate_q && s.ucur),
    .done_o (ol_done)
  );

  lsd_bypass u_byp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clamp_i (s.clamp),
    .rearm_i (in_fall || en_fall),
    .off_i   (!gate_q),
    .byp_i   (s.byp),
    .blk_o   (byp_blk),
    .fault_o (byp_fault)
  );

  always_comb begin
    ovl_d = ovl_q;
    if (in_fall) begin
      ovl_d = 1'b0;
    end else if (ovl_done) begin
      ovl_d = 1'b1;
    end
  end

  always_comb begin
    fault_c = s.ot || ovl_q
           || (!gate_q && (s.uvolt || byp_fault))
           || (gate_q && ol_done);
    gate_d  = cmd && !ovl_q && !s.ot;
    diag_d  = !fault_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_q  <= 1'b0;
      gate_q <= 1'b0;
      diag_q <= 1'b1;
    end else begin
      ovl_q  <= ovl_d;
      gate_q <= gate_d;
      diag_q <= diag_d;
    end
  end

  assign gate_o   = gate_q;
  assign diag_n_o = diag_q;
endmodule

// File: rtl/lsd_fault_ctrl_chk.sv
module lsd_fault_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic in_i,
  input logic otemp_i,
  input logic gate_o,
  input logic diag_n_o,
  input logic ovl_q,
  input logic in_fall,
  input logic clamp_s,
  input logic byp_blk
);
  a_r1_gate_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> ($past(en_i, 3) && $past(in_i, 3)));

  a_r4_hot_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(otemp_i, 3) |-> (!gate_o && !diag_n_o));

  a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_q && !in_fall) |=> ovl_q);

  a_r3_latch_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_q |=> !gate_o);

  a_r7_clamp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_s |=> byp_blk);
endmodule

bind lsd_fault_ctrl lsd_fault_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_i     (en_i),
  .in_i     (in_i),
  .otemp_i  (otemp_i),
  .gate_o   (gate_o),
  .diag_n_o (diag_n_o),
  .ovl_q    (ovl_q),
  .in_fall  (in_fall),
  .clamp_s  (s.clamp),
  .byp_blk  (byp_blk)
);

// File: tb/test_lsd_fault_ctrl.sv
module test_lsd_fault_ctrl;
  localparam int OVL_T  = 6;
  localparam int OPEN_T = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic en_i = 1'b0, in_i = 1'b0, oc_i = 1'b0, ucur_i = 1'b0;
  logic uvolt_i = 1'b0, byp_i = 1'b0, clamp_i = 1'b0, otemp_i = 1'b0;
  logic gate_o, diag_n_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [1:0] tdiv = 2'd0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= tdiv + 2'd1;
    tick_us <= (tdiv == 2'd3);
  end

  lsd_fault_ctrl #(.OVL_TICKS(OVL_T), .OPEN_TICKS(OPEN_T)) i_lsd_fault_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .en_i(en_i), .in_i(in_i),
    .oc_i(oc_i), .ucur_i(ucur_i), .uvolt_i(uvolt_i), .byp_i(byp_i),
    .clamp_i(clamp_i), .otemp_i(otemp_i), .gate_o(gate_o), .diag_n_o(diag_n_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    en_i = 0; in_i = 0; oc_i = 0; ucur_i = 0;
    uvolt_i = 0; byp_i = 0; clamp_i = 0; otemp_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R10 reset state
    chk("R10", "gate in reset", gate_o, 1'b0);
    chk("R10", "diag in reset", diag_n_o, 1'b1);
    rst_n = 1'b1;
    cyc(4);

    // Sweep of static flag combinations: R1 R4 R6 R7 R8 R9
    for (int v = 0; v < 64; v++) begin
      logic eg, ed;
      en_i = v[0]; in_i = v[1]; otemp_i = v[2];
      uvolt_i = v[3]; byp_i = v[4]; ucur_i = v[5];
      cyc(40);
      eg = v[0] & v[1] & ~v[2];
      ed = ~(v[2] | (~eg & (v[3] | v[4])) | (eg & v[5]));
      chk("R1", "sweep gate", gate_o, eg);
      chk("R9", "sweep diag", diag_n_o, ed);
    end
    quiet(); cyc(12);

    // R1 latency
    en_i = 1; in_i = 1;
    cyc(2); chk("R1", "gate before 3 cycles", gate_o, 1'b0);
    cyc(1); chk("R1", "gate at 3 cycles", gate_o, 1'b1);

    // R2 short overcurrent pulses restart the count
    for (int k = 0; k < 4; k++) begin
      oc_i = 1; cyc(16); oc_i = 0; cyc(8);
    end
    chk("R2", "gate after short pulses", gate_o, 1'b1);
    oc_i = 1; cyc(12);
    chk("R2", "gate during delay", gate_o, 1'b1);
    cyc(40);
    chk("R2", "gate after delay", gate_o, 1'b0);
    chk("R3", "diag latched", diag_n_o, 1'b0);
    oc_i = 0; cyc(20);
    chk("R3", "gate held after oc clears", gate_o, 1'b0);
    chk("R3", "diag held after oc clears", diag_n_o, 1'b0);
    en_i = 0; cyc(12); en_i = 1; cyc(12);
    chk("R3", "enable pulse does not clear", gate_o, 1'b0);
    in_i = 0; cyc(12);
    chk("R3", "diag after input fall", diag_n_o, 1'b1);
    in_i = 1; cyc(12);
    chk("R3", "gate after clear", gate_o, 1'b1);

    // R4 over-temperature and recovery
    otemp_i = 1; cyc(12);
    chk("R4", "gate hot", gate_o, 1'b0);
    chk("R4", "diag hot", diag_n_o, 1'b0);
    otemp_i = 0; cyc(12);
    chk("R4", "gate recovered", gate_o, 1'b1);
    chk("R4", "diag recovered", diag_n_o, 1'b1);

    // R5 over-temperature with overcurrent latches
    otemp_i = 1; oc_i = 1; cyc(60);
    otemp_i = 0; oc_i = 0; cyc(12);
    chk("R5", "gate latched after hot", gate_o, 1'b0);
    chk("R5", "diag latched after hot", diag_n_o, 1'b0);
    in_i = 0; cyc(12); in_i = 1; cyc(12);
    chk("R5", "gate after clear", gate_o, 1'b1);

    // R8 open load while on
    for (int k = 0; k < 4; k++) begin
      ucur_i = 1; cyc(8); ucur_i = 0; cyc(8);
    end
    chk("R8", "diag after short gaps", diag_n_o, 1'b1);
    ucur_i = 1; cyc(12);
    chk("R8", "diag before delay", diag_n_o, 1'b1);
    cyc(30);
    chk("R8", "diag after delay", diag_n_o, 1'b0);
    ucur_i = 0; cyc(8);

    // R6 low voltage while off
    in_i = 0; uvolt_i = 1; cyc(8);
    chk("R6", "diag low voltage off", diag_n_o, 1'b0);
    uvolt_i = 0; cyc(8);
    chk("R9", "diag off healthy", diag_n_o, 1'b1);

    // R7 bypass with clamp blanking and re-arm
    byp_i = 1; cyc(8);
    chk("R7", "diag bypass", diag_n_o, 1'b0);
    clamp_i = 1; cyc(8); clamp_i = 0; cyc(20);
    chk("R7", "diag blocked after clamp", diag_n_o, 1'b1);
    in_i = 1; cyc(12);
    chk("R7", "diag on with bypass flag", diag_n_o, 1'b1);
    in_i = 0; cyc(8);
    chk("R7", "diag rearmed by input fall", diag_n_o, 1'b0);
    clamp_i = 1; cyc(8); clamp_i = 0; cyc(12);
    chk("R7", "diag blocked again", diag_n_o, 1'b1);
    en_i = 0; cyc(8);
    chk("R7", "diag rearmed by enable fall", diag_n_o, 1'b0);
    byp_i = 0; en_i = 1; in_i = 1; cyc(12);
    chk("R1", "gate on again", gate_o, 1'b1);

    // R10 reset while running
    @(negedge clk); rst_n = 0;
    #1;
    chk("R10", "gate on reset", gate_o, 1'b0);
    chk("R10", "diag on reset", diag_n_o, 1'b1);
    cyc(3); rst_n = 1; cyc(12);
    chk("R10", "gate after reset release", gate_o, 1'b1);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule